// File: doc/BRIEF.md
# Oscilloscope Internal Trigger Source Selector

This block decides which vertical channel's trigger pickoff reaches the internal trigger path. It also holds the channel switch state that chooses the displayed channel. It takes four kinds of input. The first is the operator's trigger source choice: channel 1, channel 2, or follow the vertical display. The second is the display selection: channel 1 only, both channels, or channel 2 only. When both channels are shown, a combine mode picks between add, alternate and chopped display. The last kind covers the X-Y flag and two single-cycle strobes, one at the end of each sweep and one from the chop clock.

The block drives two channel display enables and two trigger select lines. Each select line is cross-wired: the first line enables the channel 2 pickoff when high, and the second line enables the channel 1 pickoff when high. Each line is the AND of a forcing term and a term derived from the display mode. A low forcing term pins its line low whatever the mode logic asks for. This is how a fixed source, chopped display and X-Y operation override the rule that the trigger follows the displayed channel. When both lines are low, neither channel's pickoff is enabled directly, and the trigger path uses the sum of both channels.

All controls are plain level pins; there is no streaming data path. Every output is registered on the system clock.

Top module: `trig_src_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its reset state: `ch1_en`=1, `ch2_en`=0, `tline1`=0, `tline2`=1, and the internal channel state selects channel 1.
- R2: Outputs update at the clock edge that samples the inputs, one register stage deep. The input codes are as follows. `src`: 0=channel 1, 1=channel 2, 2 or 3=follow display. `disp`: 0=channel 1 only, 1 or 3=both, 2=channel 2 only. `bmode`: 0 or 3=add, 1=alternate, 2=chop. With `disp`=0 the enables are 1,0; with `disp`=2 they are 0,1.
- R3: With `src`=0 and `xy`=0, `tline1`=0 and `tline2`=1.
- R4: With `src`=2'd1 and `xy`=0, `tline2`=0 and `tline1`=1.
- R5: With a follow-display source and no chop override, `tline1` is the inverse of `ch1_en` and `tline2` is the inverse of `ch2_en`.
- R6: With both channels displayed in add mode, both enables are 1, and under a follow-display source both lines are 0.
- R7: In alternate mode with both channels displayed, each `alt_sync` strobe toggles the channel state. The enables follow that state: channel 1 gives 1,0 and channel 2 gives 0,1.
- R8: In chop mode with both channels displayed, each `chop_tick` strobe toggles the channel state and the enables follow it. Under a follow-display source, both lines are held 0.
- R9: A strobe that does not belong to the current mode leaves the channel state unchanged. This covers `chop_tick` in alternate mode, `alt_sync` in add or chop mode, and either strobe when a single channel is displayed.
- R10: With `xy`=1, the enables are 0,1, `tline1`=0 and `tline2`=1, whatever `src` and `disp` are, and the channel state is set to channel 2.
- R11: `tline1` and `tline2` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src | input | 2 | Internal trigger source code |
| disp | input | 2 | Display channel selection code |
| bmode | input | 2 | Combine mode used when both channels are shown |
| xy | input | 1 | X-Y operation flag |
| alt_sync | input | 1 | End-of-sweep strobe, one cycle |
| chop_tick | input | 1 | Chop clock strobe, one cycle |
| ch1_en | output | 1 | Channel 1 display enable |
| ch2_en | output | 1 | Channel 2 display enable |
| tline1 | output | 1 | High enables the channel 2 pickoff |
| tline2 | output | 1 | High enables the channel 1 pickoff |

## Verification
The only hidden state is the one-bit channel state. If it is wrong, the enable pair in alternate or chop display comes out swapped, and under a follow-display source both trigger lines swap with it. A lost or extra toggle shows at the edge that samples the strobe. A corrupted state stays hidden while a single channel, add mode or X-Y is selected, and appears at the first edge after the display returns to alternate or chop. The bench therefore reads the state back through that mode after every stimulus that should not touch it.

// File: rtl/trig_src_pkg.sv
package trig_src_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    SRC_CH1  = 2'd0,
    SRC_CH2  = 2'd1,
    SRC_FOL  = 2'd2,
    SRC_FOL3 = 2'd3
  } src_e;

  typedef enum logic [CODE_W-1:0] {
    DSP_CH1   = 2'd0,
    DSP_BOTH  = 2'd1,
    DSP_CH2   = 2'd2,
    DSP_BOTH3 = 2'd3
  } disp_e;

  typedef enum logic [CODE_W-1:0] {
    BM_ADD  = 2'd0,
    BM_ALT  = 2'd1,
    BM_CHOP = 2'd2,
    BM_ADD3 = 2'd3
  } bmode_e;

  typedef struct packed {
    logic both;
    logic alt;
    logic chop;
    logic fol;
    logic s1;
    logic s2;
  } dec_t;
endpackage

// File: rtl/trig_mode_dec.sv
module trig_mode_dec
  import trig_src_pkg::*;
(
  input  logic [CODE_W-1:0] src,
  input  logic [CODE_W-1:0] disp,
  input  logic [CODE_W-1:0] bmode,
  output dec_t              dec
);
  always_comb begin
    dec.both = (disp == DSP_BOTH) || (disp == DSP_BOTH3);
    dec.alt  = (bmode == BM_ALT);
    dec.chop = (bmode == BM_CHOP);
    dec.s1   = (src == SRC_CH1);
    dec.s2   = (src == SRC_CH2);
    dec.fol  = (src == SRC_FOL) || (src == SRC_FOL3);
  end
endmodule

// File: rtl/trig_chan_sw.sv
module trig_chan_sw
  import trig_src_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] disp,
  input  dec_t              dec,
  input  logic              xy,
  input  logic              alt_sync,
  input  logic              chop_tick,
  output logic              en1_nx,
  output logic              en2_nx,
  output logic              en1,
  output logic              en2
);
  logic st, st_nx, flip;

  always_comb begin
    flip = dec.both && ((dec.alt && alt_sync) || (dec.chop && chop_tick));
    if (xy)        st_nx = 1'b1;
    else if (flip) st_nx = ~st;
    else           st_nx = st;

    if (xy) begin
      en1_nx = 1'b0; en2_nx = 1'b1;
    end else if (disp == DSP_CH1) begin
      en1_nx = 1'b1; en2_nx = 1'b0;
    end else if (disp == DSP_CH2) begin
      en1_nx = 1'b0; en2_nx = 1'b1;
    end else if (!dec.alt && !dec.chop) begin
      en1_nx = 1'b1; en2_nx = 1'b1;
    end else begin
      en1_nx = ~st_nx; en2_nx = st_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= 1'b0;
      en1 <= 1'b1;
      en2 <= 1'b0;
    end else begin
      st  <= st_nx;
      en1 <= en1_nx;
      en2 <= en2_nx;
    end
  end

  AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(xy) && $past(dec.both) && $past(dec.alt) && $past(alt_sync))
      |-> (st != $past(st))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(xy) && !$past(dec.both)) |-> (st == $past(st))); // R9

  AST_XY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(xy)) |-> (st && !en1 && en2)); // R10

  AST_EN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (en1 || en2)); // R2
endmodule

// File: rtl/trig_line_gate.sv
module trig_line_gate
  import trig_src_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  dec_t dec,
  input  logic xy,
  input  logic en1_nx,
  input  logic en2_nx,
  output logic tline1,
  output logic tline2
);
  logic chop_ovr, frc1, frc2, vgate, mode1, mode2;

  always_comb begin
    chop_ovr = dec.fol && dec.both && dec.chop;
    frc1  = !(xy || dec.s1 || chop_ovr);
    frc2  = !(!xy && (dec.s2 || chop_ovr));
    vgate = dec.fol && !xy;
    mode1 = !(vgate && en1_nx);
    mode2 = !(vgate && en2_nx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tline1 <= 1'b0;
      tline2 <= 1'b1;
    end else begin
      tline1 <= frc1 & mode1;
      tline2 <= frc2 & mode2;
    end
  end

  AST_NO_DUAL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(tline1 && tline2)); // R11

  AST_CHOP_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(xy) && $past(chop_ovr)) |-> (!tline1 && !tline2)); // R8

  AST_SRC1_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dec.s1)) |-> (!tline1 && tline2)); // R3
endmodule

// File: rtl/trig_src_sel.sv
module trig_src_sel
  import trig_src_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] src,
  input  logic [CODE_W-1:0] disp,
  input  logic [CODE_W-1:0] bmode,
  input  logic              xy,
  input  logic              alt_sync,
  input  logic              chop_tick,
  output logic              ch1_en,
  output logic              ch2_en,
  output logic              tline1,
  output logic              tline2
);
  dec_t dec;
  logic en1_nx, en2_nx;

  trig_mode_dec u_dec (
    .src(src), .disp(disp), .bmode(bmode), .dec(dec)
  );

  trig_chan_sw u_sw (
    .clk(clk), .rst_n(rst_n), .disp(disp), .dec(dec), .xy(xy),
    .alt_sync(alt_sync), .chop_tick(chop_tick),
    .en1_nx(en1_nx), .en2_nx(en2_nx), .en1(ch1_en), .en2(ch2_en)
  );

  trig_line_gate u_gate (
    .clk(clk), .rst_n(rst_n), .dec(dec), .xy(xy),
    .en1_nx(en1_nx), .en2_nx(en2_nx), .tline1(tline1), .tline2(tline2)
  );

  AST_XY_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(xy)) |-> (!tline1 && tline2)); // R10

  AST_ADD_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(xy) && $past(dec.both) && !$past(dec.alt) && !$past(dec.chop))
      |-> (ch1_en && ch2_en)); // R6
endmodule

// File: tb/trig_src_sel_test.sv
module trig_src_sel_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src = 2'd0, disp = 2'd0, bmode = 2'd0;
  logic xy = 1'b0, alt_sync = 1'b0, chop_tick = 1'b0;
  logic ch1_en, ch2_en, tline1, tline2;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_src_sel uut (
    .clk(clk), .rst_n(rst_n), .src(src), .disp(disp), .bmode(bmode),
    .xy(xy), .alt_sync(alt_sync), .chop_tick(chop_tick),
    .ch1_en(ch1_en), .ch2_en(ch2_en), .tline1(tline1), .tline2(tline2)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect4(input string req, input logic e1, input logic e2,
                         input logic l1, input logic l2);
    checks++;
    if ({ch1_en, ch2_en, tline1, tline2} !== {e1, e2, l1, l2}) begin
      errors++;
      $display("FAIL %s: en1 en2 l1 l2 = %b%b%b%b expected %b%b%b%b",
               req, ch1_en, ch2_en, tline1, tline2, e1, e2, l1, l2);
    end
  endtask

  task automatic pulse_alt();
    alt_sync = 1'b1; step(); alt_sync = 1'b0;
  endtask

  task automatic pulse_chop();
    chop_tick = 1'b1; step(); chop_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; src = 2'd1; disp = 2'd2; xy = 1'b1;
    step(); step();
    expect4("R1 reset", 1, 0, 0, 1);
    xy = 1'b0; src = 2'd0; disp = 2'd0;
    rst_n = 1'b1;
  endtask

  task automatic t_fixed_src();
    src = 2'd0; disp = 2'd0; step();
    expect4("R3 src ch1", 1, 0, 0, 1);
    src = 2'd1; step();
    expect4("R4 src ch2", 1, 0, 1, 0);
    disp = 2'd2; step();
    expect4("R2 disp ch2 only", 0, 1, 1, 0);
  endtask

  task automatic t_follow();
    src = 2'd2; disp = 2'd2; step();
    expect4("R5 follow ch2", 0, 1, 1, 0);
    disp = 2'd0; step();
    expect4("R5 follow ch1", 1, 0, 0, 1);
    checks++;
    if (tline1 && tline2) begin
      errors++;
      $display("FAIL R11: both lines high, expected at most one");
    end
  endtask

  task automatic t_add();
    src = 2'd2; disp = 2'd1; bmode = 2'd0; step();
    expect4("R6 add", 1, 1, 0, 0);
    pulse_alt();
    bmode = 2'd1; step();
    expect4("R9 alt_sync in add ignored", 1, 0, 0, 1);
  endtask

  task automatic t_alt();
    src = 2'd2; disp = 2'd1; bmode = 2'd1; step();
    expect4("R7 alt start ch1", 1, 0, 0, 1);
    pulse_alt();
    expect4("R7 alt swap to ch2", 0, 1, 1, 0);
    step();
    expect4("R7 alt holds without strobe", 0, 1, 1, 0);
    pulse_chop();
    expect4("R9 chop_tick in alt ignored", 0, 1, 1, 0);
    pulse_alt();
    expect4("R7 alt swap back", 1, 0, 0, 1);
  endtask

  task automatic t_chop();
    src = 2'd2; disp = 2'd1; bmode = 2'd2; step();
    expect4("R8 chop lines low", 1, 0, 0, 0);
    pulse_chop();
    expect4("R8 chop toggle", 0, 1, 0, 0);
    pulse_alt();
    expect4("R9 alt_sync in chop ignored", 0, 1, 0, 0);
    src = 2'd0; step();
    expect4("R3 src ch1 in chop", 0, 1, 0, 1);
  endtask

  task automatic t_single_ignore();
    src = 2'd2; disp = 2'd0; bmode = 2'd2; step();
    pulse_chop();
    expect4("R9 single disp chop_tick", 1, 0, 0, 1);
    disp = 2'd1; step();
    expect4("R9 state kept through single disp", 0, 1, 0, 0);
  endtask

  task automatic t_xy();
    src = 2'd1; disp = 2'd0; bmode = 2'd1; xy = 1'b1; step();
    pulse_chop();
    pulse_alt();
    expect4("R10 xy overrides", 0, 1, 0, 1);
    xy = 1'b0; src = 2'd2; disp = 2'd1; step();
    expect4("R10 xy left state ch2", 0, 1, 1, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_fixed_src();
        t_follow();
        t_add();
        t_alt();
        t_chop();
        t_single_ignore();
        t_xy();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule